// File: doc/BRIEF.md
# Per-Queue Head/Tail Cell Cache over Wide Bulk Memory

This block buffers fixed-size cells for a set of logical FIFO queues that share one slow, wide bulk memory. Each queue owns a small fast tail store that collects arrivals and a small fast head store that feeds departures. Once a tail store holds a full block of `B` cells, the block moves to the queue's region of bulk memory in a single wide write. Head stores are topped up from bulk memory one block at a time. This lets the outside world enqueue one cell and dequeue one cell every clock, while the bulk memory sees only one wide access every `B/2` cycles.

An arbiter owns the bulk port. On each access slot it prefers the direction that did not get the previous slot, but gives the slot to the other direction when the preferred one has no candidate. Flush candidates are served round-robin. The refill candidate is the queue whose head store is emptiest. A queue with nothing in bulk memory and nothing in flight is served straight from its tail store, so short queues never take the round trip. A departure request returns one outcome one cycle later: a cell, a miss (the queue holds cells but none are at the head yet), or an underflow (the queue is empty).

Top module: `pcache_top`

## Requirements
- R1: While reset is held and after its release, `deq_vld`, `deq_miss`, `deq_uflow`, `enq_drop` and `deq_data` are 0, and every queue starts empty.
- R2: Cells leave each queue in exactly the order in which they were accepted into it, whatever path they took through the tail store, the bulk memory and the head store.
- R3: Each cycle with `deq_req` high produces, on the next cycle, exactly one of `deq_vld`, `deq_miss` and `deq_uflow`. A cycle without a request produces none of them on the next cycle.
- R4: A departure request to a queue that holds no cells (judged before any arrival in the same cycle) gives `deq_uflow` and is otherwise ignored. Later arrivals to that queue leave in order, unaffected.
- R5: When a queue has nothing in bulk memory, nothing in its head store and no refill in flight, a request is served from its tail store with `deq_vld` on the next cycle and no miss.
- R6: An arrival to a queue whose tail store already holds 2·B cells is dropped. `enq_drop` is raised on the next cycle and the queue's contents are unchanged.
- R7: The bulk port performs at most one access, reading or writing B cells, in any B/2 cycles. A queue given 2·B cells and left idle long enough then serves 2·B back-to-back requests with `deq_vld` on every one.
- R8: Under sustained arrivals with no departures, a queue fills to exactly 2·B (head) + BLKS·B (bulk) + 2·B (tail) cells and then drops.
- R9: A miss never loses a cell. Repeating requests drains every accepted cell within a bounded number of cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| enq_valid | input | 1 | Arrival of one cell this cycle |
| enq_qid | input | $clog2(NQ) | Queue of the arriving cell |
| enq_data | input | W | Arriving cell |
| deq_req | input | 1 | Departure request this cycle |
| deq_qid | input | $clog2(NQ) | Queue of the departure request |
| deq_vld | output | 1 | Registered: the request of the previous cycle returned a cell |
| deq_data | output | W | Registered: the departing cell (0 when none) |
| deq_miss | output | 1 | Registered: the queue had cells but none ready at the head |
| deq_uflow | output | 1 | Registered: the request hit an empty queue and was ignored |
| enq_drop | output | 1 | Registered: the previous cycle's arrival was dropped |

## Verification
The assertions check on every cycle that each request gets exactly one outcome and that cycles without a request get none. They also check that drops only follow arrivals, that the bulk port never reads and writes at once, and that bulk accesses keep the slot spacing. Cell ordering, underflow only on truly empty queues, the bypass path, fill-to-capacity and the eventual draining of every accepted cell depend on history across queues. Only the bench shows these, by running its per-queue reference FIFOs through directed cases and long random traffic.

// File: rtl/pcache_pkg.sv
package pcache_pkg;
  typedef enum logic {
    XF_FLUSH = 1'b0,
    XF_FILL  = 1'b1
  } xfer_e;
endpackage

// File: rtl/pcache_tail.sv
// Per-queue tail stores: single-cell push, single-cell bypass pop, block pop.
module pcache_tail #(
  parameter int NQ  = 4,
  parameter int W   = 8,
  parameter int B   = 4,
  parameter int CAP = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       push,
  input  logic [$clog2(NQ)-1:0]      push_q,
  input  logic [W-1:0]               push_d,
  input  logic                       pop_one,
  input  logic [$clog2(NQ)-1:0]      one_q,
  output logic [W-1:0]               one_d,
  input  logic                       pop_blk,
  input  logic [$clog2(NQ)-1:0]      blk_q,
  output logic [B*W-1:0]             blk_d,
  output logic [$clog2(CAP):0]       cnt [NQ]
);
  localparam int QW = $clog2(NQ);
  localparam int PW = $clog2(CAP);

  logic [W-1:0]  mem [NQ][CAP];
  logic [PW-1:0] rd_q [NQ];
  logic [PW-1:0] rd_n [NQ];
  logic [PW-1:0] wr_q [NQ];
  logic [PW-1:0] wr_n [NQ];
  logic [PW:0]   cnt_q [NQ];
  logic [PW:0]   cnt_n [NQ];

  always_comb begin
    for (int q = 0; q < NQ; q++) begin
      rd_n[q]  = rd_q[q];
      wr_n[q]  = wr_q[q];
      cnt_n[q] = cnt_q[q];
      if (push && push_q == QW'(q)) begin
        wr_n[q]  = wr_q[q] + 1'b1;
        cnt_n[q] = cnt_n[q] + 1'b1;
      end
      if (pop_one && one_q == QW'(q)) begin
        rd_n[q]  = rd_n[q] + 1'b1;
        cnt_n[q] = cnt_n[q] - 1'b1;
      end
      if (pop_blk && blk_q == QW'(q)) begin
        rd_n[q]  = rd_n[q] + PW'(B);
        cnt_n[q] = cnt_n[q] - (PW+1)'(B);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int q = 0; q < NQ; q++) begin
        rd_q[q]  <= '0;
        wr_q[q]  <= '0;
        cnt_q[q] <= '0;
      end
    end else begin
      for (int q = 0; q < NQ; q++) begin
        rd_q[q]  <= rd_n[q];
        wr_q[q]  <= wr_n[q];
        cnt_q[q] <= cnt_n[q];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[push_q][wr_q[push_q]] <= push_d;
  end

  assign one_d = mem[one_q][rd_q[one_q]];

  for (genvar i = 0; i < B; i++) begin : g_blk
    assign blk_d[i*W +: W] = mem[blk_q][rd_q[blk_q] + PW'(i)];
  end

  always_comb begin
    for (int q = 0; q < NQ; q++) cnt[q] = cnt_q[q];
  end
endmodule

// File: rtl/pcache_head.sv
// Per-queue head stores: block push from bulk memory, single-cell pop.
module pcache_head #(
  parameter int NQ  = 4,
  parameter int W   = 8,
  parameter int B   = 4,
  parameter int CAP = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       push,
  input  logic [$clog2(NQ)-1:0]      push_q,
  input  logic [B*W-1:0]             push_d,
  input  logic                       pop,
  input  logic [$clog2(NQ)-1:0]      pop_q,
  output logic [W-1:0]               pop_d,
  output logic [$clog2(CAP):0]       cnt [NQ]
);
  localparam int QW = $clog2(NQ);
  localparam int PW = $clog2(CAP);

  logic [W-1:0]  mem [NQ][CAP];
  logic [PW-1:0] rd_q [NQ];
  logic [PW-1:0] rd_n [NQ];
  logic [PW-1:0] wr_q [NQ];
  logic [PW-1:0] wr_n [NQ];
  logic [PW:0]   cnt_q [NQ];
  logic [PW:0]   cnt_n [NQ];

  always_comb begin
    for (int q = 0; q < NQ; q++) begin
      rd_n[q]  = rd_q[q];
      wr_n[q]  = wr_q[q];
      cnt_n[q] = cnt_q[q];
      if (push && push_q == QW'(q)) begin
        wr_n[q]  = wr_q[q] + PW'(B);
        cnt_n[q] = cnt_n[q] + (PW+1)'(B);
      end
      if (pop && pop_q == QW'(q)) begin
        rd_n[q]  = rd_q[q] + 1'b1;
        cnt_n[q] = cnt_n[q] - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int q = 0; q < NQ; q++) begin
        rd_q[q]  <= '0;
        wr_q[q]  <= '0;
        cnt_q[q] <= '0;
      end
    end else begin
      for (int q = 0; q < NQ; q++) begin
        rd_q[q]  <= rd_n[q];
        wr_q[q]  <= wr_n[q];
        cnt_q[q] <= cnt_n[q];
      end
    end
  end

  for (genvar i = 0; i < B; i++) begin : g_wr
    always_ff @(posedge clk) begin
      if (push) mem[push_q][wr_q[push_q] + PW'(i)] <= push_d[i*W +: W];
    end
  end

  assign pop_d = mem[pop_q][rd_q[pop_q]];

  always_comb begin
    for (int q = 0; q < NQ; q++) cnt[q] = cnt_q[q];
  end
endmodule

// File: rtl/pcache_bulk.sv
// Behavioural wide bulk memory: immediate write, fixed read latency with tag.
module pcache_bulk #(
  parameter int DEPTH = 16,
  parameter int DW    = 32,
  parameter int TW    = 2,
  parameter int LAT   = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en,
  input  logic [$clog2(DEPTH)-1:0]  wr_addr,
  input  logic [DW-1:0]             wr_data,
  input  logic                      rd_en,
  input  logic [$clog2(DEPTH)-1:0]  rd_addr,
  input  logic [TW-1:0]             rd_tag,
  output logic                      rd_vld,
  output logic [TW-1:0]             rd_tag_o,
  output logic [DW-1:0]             rd_data
);
  logic [DW-1:0] mem [DEPTH];
  logic          vld_s [LAT];
  logic [TW-1:0] tag_s [LAT];
  logic [DW-1:0] dat_s [LAT];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_s[0] <= 1'b0;
    else        vld_s[0] <= rd_en;
  end

  always_ff @(posedge clk) begin
    if (rd_en) begin
      tag_s[0] <= rd_tag;
      dat_s[0] <= mem[rd_addr];
    end
  end

  for (genvar s = 1; s < LAT; s++) begin : g_pipe
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) vld_s[s] <= 1'b0;
      else        vld_s[s] <= vld_s[s-1];
    end
    always_ff @(posedge clk) begin
      if (vld_s[s-1]) begin
        tag_s[s] <= tag_s[s-1];
        dat_s[s] <= dat_s[s-1];
      end
    end
  end

  assign rd_vld   = vld_s[LAT-1];
  assign rd_tag_o = tag_s[LAT-1];
  assign rd_data  = dat_s[LAT-1];
endmodule

// File: rtl/pcache_arb.sv
// Bulk-port arbiter: slot timer, alternating direction, round-robin flush,
// emptiest-head refill.
module pcache_arb
  import pcache_pkg::*;
#(
  parameter int NQ   = 4,
  parameter int B    = 4,
  parameter int TCAP = 8,
  parameter int HCAP = 8,
  parameter int BLKS = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [$clog2(TCAP):0]       tcnt [NQ],
  input  logic [$clog2(HCAP):0]       hcnt [NQ],
  input  logic [$clog2(BLKS):0]       bcnt [NQ],
  input  logic [NQ-1:0]               infl,
  input  logic                        byp_v,
  input  logic [$clog2(NQ)-1:0]       byp_q,
  output logic                        flush_go,
  output logic                        fill_go,
  output logic [$clog2(NQ)-1:0]       go_q
);
  localparam int QW   = $clog2(NQ);
  localparam int TW   = $clog2(TCAP) + 1;
  localparam int HW   = $clog2(HCAP) + 1;
  localparam int BW   = $clog2(BLKS) + 1;
  localparam int SLOT = (B / 2 > 0) ? B / 2 : 1;
  localparam int SW   = (SLOT > 1) ? $clog2(SLOT) : 1;

  logic [SW-1:0] slot_q, slot_n;
  xfer_e         pref_q, pref_n;
  logic [QW-1:0] rr_q, rr_n;

  logic [NQ-1:0] flush_ok, fill_ok;
  logic          f_any, r_any, slot;
  logic [QW-1:0] f_q, r_q;
  logic [HW-1:0] r_best;

  always_comb begin
    for (int q = 0; q < NQ; q++) begin
      flush_ok[q] = (tcnt[q] >= TW'(B)) && (bcnt[q] != BW'(BLKS)) &&
                    !(byp_v && byp_q == QW'(q));
      fill_ok[q]  = (bcnt[q] != '0) && !infl[q] && (hcnt[q] <= HW'(HCAP - B));
    end
  end

  always_comb begin
    f_any = 1'b0;
    f_q   = '0;
    for (int k = 0; k < NQ; k++) begin
      if (!f_any && flush_ok[rr_q + QW'(k)]) begin
        f_any = 1'b1;
        f_q   = rr_q + QW'(k);
      end
    end
  end

  always_comb begin
    r_any  = 1'b0;
    r_q    = '0;
    r_best = '1;
    for (int q = 0; q < NQ; q++) begin
      if (fill_ok[q] && hcnt[q] < r_best) begin
        r_any  = 1'b1;
        r_q    = QW'(q);
        r_best = hcnt[q];
      end
    end
  end

  always_comb begin
    slot     = (slot_q == '0);
    flush_go = 1'b0;
    fill_go  = 1'b0;
    go_q     = '0;
    if (slot) begin
      if (pref_q == XF_FLUSH && f_any) begin
        flush_go = 1'b1;
        go_q     = f_q;
      end else if (r_any) begin
        fill_go = 1'b1;
        go_q    = r_q;
      end else if (f_any) begin
        flush_go = 1'b1;
        go_q     = f_q;
      end
    end
    slot_n = slot ? SW'(SLOT - 1) : slot_q - 1'b1;
    pref_n = pref_q;
    rr_n   = rr_q;
    if (flush_go) begin
      pref_n = XF_FILL;
      rr_n   = f_q + 1'b1;
    end else if (fill_go) begin
      pref_n = XF_FLUSH;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_q <= '0;
      pref_q <= XF_FLUSH;
      rr_q   <= '0;
    end else begin
      slot_q <= slot_n;
      pref_q <= pref_n;
      rr_q   <= rr_n;
    end
  end
endmodule

// File: rtl/pcache_top.sv
module pcache_top #(
  parameter int NQ   = 4,
  parameter int B    = 4,
  parameter int W    = 8,
  parameter int BLKS = 4,
  parameter int LAT  = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   enq_valid,
  input  logic [$clog2(NQ)-1:0]  enq_qid,
  input  logic [W-1:0]           enq_data,
  input  logic                   deq_req,
  input  logic [$clog2(NQ)-1:0]  deq_qid,
  output logic                   deq_vld,
  output logic [W-1:0]           deq_data,
  output logic                   deq_miss,
  output logic                   deq_uflow,
  output logic                   enq_drop
);
  localparam int QW   = $clog2(NQ);
  localparam int TCAP = 2 * B;
  localparam int HCAP = 2 * B;
  localparam int TW   = $clog2(TCAP) + 1;
  localparam int HW   = $clog2(HCAP) + 1;
  localparam int BPW  = $clog2(BLKS);
  localparam int DEP  = NQ * BLKS;

  // reset: asynchronous assertion, synchronous release
  logic rst_m_n, rst_s_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_m_n <= 1'b0;
      rst_s_n <= 1'b0;
    end else begin
      rst_m_n <= 1'b1;
      rst_s_n <= rst_m_n;
    end
  end

  logic [TW-1:0]    tcnt [NQ];
  logic [HW-1:0]    hcnt [NQ];
  logic [BPW:0]     bcnt_q [NQ];
  logic [BPW:0]     bcnt_n [NQ];
  logic [BPW-1:0]   bwp_q [NQ];
  logic [BPW-1:0]   bwp_n [NQ];
  logic [BPW-1:0]   brp_q [NQ];
  logic [BPW-1:0]   brp_n [NQ];
  logic [NQ-1:0]    infl_q, infl_n;

  logic             flush_go, fill_go;
  logic [QW-1:0]    go_q;
  logic [W-1:0]     tail_d, head_d;
  logic [B*W-1:0]   tail_blk;
  logic             bulk_wr, bulk_rd, ret_vld;
  logic [QW-1:0]    ret_q;
  logic [B*W-1:0]   ret_d;

  logic             stage_empty, serve_head, serve_byp, enq_ok;
  logic             vld_n, miss_n, uflow_n, drop_n;
  logic [W-1:0]     data_n;

  assign bulk_wr = flush_go;
  assign bulk_rd = fill_go;

  // departure decision against the state before this cycle's arrival
  always_comb begin
    stage_empty = (hcnt[deq_qid] == '0) && (bcnt_q[deq_qid] == '0) && !infl_q[deq_qid];
    serve_head  = deq_req && (hcnt[deq_qid] != '0);
    serve_byp   = deq_req && stage_empty && (tcnt[deq_qid] != '0);
    uflow_n     = deq_req && stage_empty && (tcnt[deq_qid] == '0);
    vld_n       = serve_head || serve_byp;
    miss_n      = deq_req && !vld_n && !uflow_n;
    data_n      = serve_head ? head_d : (serve_byp ? tail_d : '0);
    enq_ok      = enq_valid && (tcnt[enq_qid] != TW'(TCAP));
    drop_n      = enq_valid && !enq_ok;
  end

  // bulk region bookkeeping
  always_comb begin
    for (int q = 0; q < NQ; q++) begin
      bwp_n[q]  = bwp_q[q];
      brp_n[q]  = brp_q[q];
      bcnt_n[q] = bcnt_q[q];
      if (flush_go && go_q == QW'(q)) begin
        bwp_n[q]  = bwp_q[q] + 1'b1;
        bcnt_n[q] = bcnt_q[q] + 1'b1;
      end
      if (fill_go && go_q == QW'(q)) begin
        brp_n[q]  = brp_q[q] + 1'b1;
        bcnt_n[q] = bcnt_q[q] - 1'b1;
      end
    end
    infl_n = infl_q;
    if (ret_vld) infl_n[ret_q] = 1'b0;
    if (fill_go) infl_n[go_q]  = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      for (int q = 0; q < NQ; q++) begin
        bwp_q[q]  <= '0;
        brp_q[q]  <= '0;
        bcnt_q[q] <= '0;
      end
      infl_q    <= '0;
      deq_vld   <= 1'b0;
      deq_miss  <= 1'b0;
      deq_uflow <= 1'b0;
      deq_data  <= '0;
      enq_drop  <= 1'b0;
    end else begin
      for (int q = 0; q < NQ; q++) begin
        bwp_q[q]  <= bwp_n[q];
        brp_q[q]  <= brp_n[q];
        bcnt_q[q] <= bcnt_n[q];
      end
      infl_q    <= infl_n;
      deq_vld   <= vld_n;
      deq_miss  <= miss_n;
      deq_uflow <= uflow_n;
      deq_data  <= data_n;
      enq_drop  <= drop_n;
    end
  end

  pcache_tail #(.NQ(NQ), .W(W), .B(B), .CAP(TCAP)) u_tail (
    .clk     (clk),
    .rst_n   (rst_s_n),
    .push    (enq_ok),
    .push_q  (enq_qid),
    .push_d  (enq_data),
    .pop_one (serve_byp),
    .one_q   (deq_qid),
    .one_d   (tail_d),
    .pop_blk (flush_go),
    .blk_q   (go_q),
    .blk_d   (tail_blk),
    .cnt     (tcnt)
  );

  pcache_head #(.NQ(NQ), .W(W), .B(B), .CAP(HCAP)) u_head (
    .clk    (clk),
    .rst_n  (rst_s_n),
    .push   (ret_vld),
    .push_q (ret_q),
    .push_d (ret_d),
    .pop    (serve_head),
    .pop_q  (deq_qid),
    .pop_d  (head_d),
    .cnt    (hcnt)
  );

  pcache_bulk #(.DEPTH(DEP), .DW(B*W), .TW(QW), .LAT(LAT)) u_bulk (
    .clk      (clk),
    .rst_n    (rst_s_n),
    .wr_en    (bulk_wr),
    .wr_addr  ({go_q, bwp_q[go_q]}),
    .wr_data  (tail_blk),
    .rd_en    (bulk_rd),
    .rd_addr  ({go_q, brp_q[go_q]}),
    .rd_tag   (go_q),
    .rd_vld   (ret_vld),
    .rd_tag_o (ret_q),
    .rd_data  (ret_d)
  );

  pcache_arb #(.NQ(NQ), .B(B), .TCAP(TCAP), .HCAP(HCAP), .BLKS(BLKS)) u_arb (
    .clk      (clk),
    .rst_n    (rst_s_n),
    .tcnt     (tcnt),
    .hcnt     (hcnt),
    .bcnt     (bcnt_q),
    .infl     (infl_q),
    .byp_v    (serve_byp),
    .byp_q    (deq_qid),
    .flush_go (flush_go),
    .fill_go  (fill_go),
    .go_q     (go_q)
  );
endmodule

// File: rtl/pcache_chk.sv
module pcache_chk #(
  parameter int SLOT = 2
) (
  input logic clk,
  input logic rst_n,
  input logic deq_req,
  input logic deq_vld,
  input logic deq_miss,
  input logic deq_uflow,
  input logic enq_valid,
  input logic enq_drop,
  input logic bus_wr,
  input logic bus_rd
);
  // R3: one outcome per request, on the following cycle
  p_one_reply_r3: assert property (@(posedge clk) disable iff (!rst_n)
    deq_req |=> ($countones({deq_vld, deq_miss, deq_uflow}) == 1));

  // R3: no outcome without a request
  p_no_reply_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !deq_req |=> !(deq_vld || deq_miss || deq_uflow));

  // R6: a drop only ever follows an arrival
  p_drop_follows_arrival_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !enq_valid |=> !enq_drop);

  // R7: a single bulk access at a time
  p_bus_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({bus_wr, bus_rd}));

  // R7: accesses keep the slot spacing
  p_bus_spacing_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((SLOT > 1) && (bus_wr || bus_rd)) |=> !(bus_wr || bus_rd));
endmodule

bind pcache_top pcache_chk #(.SLOT((B / 2 > 0) ? B / 2 : 1)) u_chk (
  .clk       (clk),
  .rst_n     (rst_s_n),
  .deq_req   (deq_req),
  .deq_vld   (deq_vld),
  .deq_miss  (deq_miss),
  .deq_uflow (deq_uflow),
  .enq_valid (enq_valid),
  .enq_drop  (enq_drop),
  .bus_wr    (bulk_wr),
  .bus_rd    (bulk_rd)
);

// File: tb/tb_pcache_top.sv
module tb_pcache_top;
  localparam int NQ   = 4;
  localparam int B    = 4;
  localparam int W    = 8;
  localparam int BLKS = 4;
  localparam int QCAP = 2 * B + 2 * B + BLKS * B;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         enq_valid, deq_req;
  logic [1:0]   enq_qid, deq_qid;
  logic [W-1:0] enq_data;
  logic         deq_vld, deq_miss, deq_uflow, enq_drop;
  logic [W-1:0] deq_data;

  always #2.5 clk = ~clk;

  pcache_top #(.NQ(NQ), .B(B), .W(W), .BLKS(BLKS), .LAT(2)) dut (
    .clk(clk), .rst_n(rst_n), .enq_valid(enq_valid), .enq_qid(enq_qid),
    .enq_data(enq_data), .deq_req(deq_req), .deq_qid(deq_qid),
    .deq_vld(deq_vld), .deq_data(deq_data), .deq_miss(deq_miss),
    .deq_uflow(deq_uflow), .enq_drop(enq_drop)
  );

  logic [W-1:0] refq [NQ][$];
  int checks = 0, fails = 0, drops_seen = 0, misses = 0;
  logic [W-1:0] dseq = 8'd1;
  bit    p_deq = 0, p_enq = 0, p_empty = 0, p_need = 0;
  int    p_dq = 0, p_eq = 0;
  string p_req = "";

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // judge the outcome of the previous cycle's inputs
  task automatic eval();
    if (p_deq) begin
      if (p_empty) begin
        chk(deq_uflow && !deq_vld && !deq_miss, "R4", "underflow on empty queue",
            {deq_vld, deq_miss, deq_uflow}, 1);
      end else begin
        chk(!deq_uflow && (deq_vld ^ deq_miss), "R3", "single outcome on busy queue",
            {deq_vld, deq_miss, deq_uflow}, 4);
        if (p_need) chk(deq_vld, p_req, "cell expected without miss", deq_vld, 1);
        if (deq_vld) begin
          chk(deq_data == refq[p_dq][0], "R2", "departure order", deq_data, refq[p_dq][0]);
          void'(refq[p_dq].pop_front());
        end
        if (deq_miss) misses++;
      end
    end else begin
      chk(!(deq_vld || deq_miss || deq_uflow), "R3", "outcome without request",
          {deq_vld, deq_miss, deq_uflow}, 0);
    end
    if (p_enq) begin
      if (enq_drop) begin
        chk(refq[p_eq].size() > 2 * B, "R6", "drop only with full tail", refq[p_eq].size(), 2 * B + 1);
        void'(refq[p_eq].pop_back());
        drops_seen++;
      end
    end else begin
      chk(!enq_drop, "R6", "drop without arrival", enq_drop, 0);
    end
  endtask

  task automatic drive(input bit ev, input int eq, input bit dv, input int dq,
                       input bit need, input string req);
    p_deq   = dv;
    p_dq    = dq;
    p_empty = dv && (refq[dq].size() == 0);
    p_need  = need;
    p_req   = req;
    p_enq   = ev;
    p_eq    = eq;
    deq_req   = dv;
    deq_qid   = 2'(dq);
    enq_valid = ev;
    enq_qid   = 2'(eq);
    enq_data  = ev ? dseq : '0;
    if (ev) begin
      refq[eq].push_back(dseq);
      dseq = dseq + 8'd1;
    end
  endtask

  task automatic step(input bit ev, input int eq, input bit dv, input int dq,
                      input bit need, input string req);
    eval();
    drive(ev, eq, dv, dq, need, req);
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, "");
  endtask

  task automatic drain(input int limit);
    int rr = 0;
    int total;
    for (int i = 0; i < limit; i++) begin
      int pick = -1;
      eval();
      for (int k = 0; k < NQ; k++)
        if (pick < 0 && refq[(rr + k) % NQ].size() != 0) pick = (rr + k) % NQ;
      if (pick < 0) begin
        drive(0, 0, 0, 0, 0, "");
        @(negedge clk);
        break;
      end
      rr = (pick + 1) % NQ;
      drive(0, 0, 1, pick, 0, "");
      @(negedge clk);
    end
    idle(1);
    total = 0;
    for (int q = 0; q < NQ; q++) total += refq[q].size();
    chk(total == 0, "R9", "all cells drained", total, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    enq_valid = 0; deq_req = 0; enq_qid = 0; deq_qid = 0; enq_data = 0;
    repeat (4) @(negedge clk);
    chk(!(deq_vld || deq_miss || deq_uflow || enq_drop) && deq_data == 0, "R1",
        "outputs in reset", {deq_vld, deq_miss, deq_uflow, enq_drop}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(!(deq_vld || deq_miss || deq_uflow || enq_drop) && deq_data == 0, "R1",
        "outputs after release", {deq_vld, deq_miss, deq_uflow, enq_drop}, 0);

    // R1/R4: every queue starts empty, requests underflow
    for (int q = 0; q < NQ; q++) step(0, 0, 1, q, 0, "");
    idle(2);

    // R4: same-cycle arrival and request on an empty queue still underflows
    step(1, 2, 1, 2, 0, "");
    idle(2);
    step(0, 0, 1, 2, 1, "R4");
    idle(2);

    // R5: short queue served from the tail store
    step(1, 1, 0, 0, 0, "");
    step(1, 1, 0, 0, 0, "");
    idle(1);
    step(0, 0, 1, 1, 1, "R5");
    step(0, 0, 1, 1, 1, "R5");
    idle(2);

    // R7: two blocks staged through bulk memory, then line-rate departures
    for (int i = 0; i < 2 * B; i++) step(1, 3, 0, 0, 0, "");
    idle(40);
    for (int i = 0; i < 2 * B; i++) step(0, 0, 1, 3, 1, "R7");
    idle(2);

    // R8/R6: fill one queue to capacity, then drop
    for (int i = 0; i < 3 * QCAP; i++) step(1, 0, 0, 0, 0, "");
    idle(40);
    chk(refq[0].size() == QCAP, "R8", "queue capacity", refq[0].size(), QCAP);
    chk(drops_seen > 0, "R6", "arrivals to full queue dropped", drops_seen, 1);
    drain(2000);

    // R2: random mixed traffic over all queues
    for (int i = 0; i < 20000; i++) begin
      bit ev = ($urandom % 10) < 7;
      bit dv = ($urandom % 10) < 6;
      step(ev, $urandom % NQ, dv, $urandom % NQ, 0, "");
    end
    drain(4000);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule